// File: doc/BRIEF.md
# ECC Error Capture Register Block

This block sits beside the error-correction datapath of a DRAM controller and records memory ECC events for software. The datapath raises a single-cycle correctable-error (CE) or uncorrectable-error (UE) pulse. Each pulse comes with the failing address, an 8-bit syndrome and a one-bit channel number. The block latches the 4 KiB block part of that address, the syndrome and the channel. It keeps one CE flag and one UE flag, and software clears each flag by writing 1 to it.

The captured information always describes the most severe error that has been logged. A UE replaces a pending CE record, but a CE never replaces anything that is logged. A second UE leaves the first UE's record in place. A per-event enable register selects which flags drive the interrupt output.

Software reaches four 32-bit words through a simple port: a 2-bit word index, a write strobe with write data, and combinational read data.

- Index 0 holds the captured address.
- Index 1 holds the syndrome and the channel.
- Index 2 holds the status flags.
- Index 3 holds the enables.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every word reads zero and `irq` is low.
- R2: A CE pulse sets status bit 0 from the next cycle. If neither flag is set at that point, the block captures the error. Word 0 then reads the failing address bits 31:12 with bits 11:0 as zero. Word 1 reads the syndrome in bits 7:0 and the channel in bit 8.
- R3: A UE pulse sets status bit 7 from the next cycle. If no UE is logged, the block captures the UE information, and this replaces a logged CE record.
- R4: A CE pulse that arrives while either flag is logged leaves words 0 and 1 unchanged. It still sets status bit 0.
- R5: A UE pulse that arrives while a UE is logged leaves words 0 and 1 unchanged.
- R6: When a CE and a UE pulse arrive in the same cycle, both flags are set and the UE information is captured.
- R7: Writing word 2 clears bit 0 where the write data has bit 0 set, and clears bit 7 where it has bit 7 set. A written 0 leaves a flag unchanged, and all other status bits read zero. In the cycle of a clear:
  - an event that arrives in that cycle still sets its flag;
  - capture is decided as though the cleared flags were already zero.
- R8: Word 3 holds the CE enable in bit 7 and the UE enable in bit 8. Writes to its other bits are ignored, and those bits read zero.
- R9: `irq` is high exactly while (status bit 0 and the CE enable are both set) or (status bit 7 and the UE enable are both set).
- R10: Writes to words 0 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable-error pulse |
| ue_evt | input | 1 | Uncorrectable-error pulse |
| err_addr | input | 32 | Failing address of the event |
| err_syn | input | 8 | ECC syndrome of the event |
| err_chan | input | 1 | Channel of the event |
| reg_idx | input | 2 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| irq | output | 1 | Error interrupt |

## Verification
Every event and every register write takes effect at the first rising edge that samples it. All flags, captured fields and `irq` are therefore due one cycle after the stimulus, while read data follows `reg_idx` within the same cycle. The bench drives inputs on falling edges and reads every word and `irq` shortly after the next falling edge, which is one full edge after the update. A bench-side model derived from the rules predicts the expected values. The sweep covers every pair of event kinds, every clear pattern applied with the second event, and every enable setting.

// File: rtl/ecc_err_log.sv
module ecc_err_log (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_evt,
  input  logic        ue_evt,
  input  logic [31:0] err_addr,
  input  logic [7:0]  err_syn,
  input  logic        err_chan,
  input  logic [1:0]  reg_idx,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam logic [1:0] IDX_ADDR = 2'd0;
  localparam logic [1:0] IDX_INFO = 2'd1;
  localparam logic [1:0] IDX_STAT = 2'd2;
  localparam logic [1:0] IDX_EN   = 2'd3;
  localparam int CE_BIT = 0;
  localparam int UE_BIT = 7;
  localparam int CE_EN_BIT = 7;
  localparam int UE_EN_BIT = 8;

  logic [19:0] blk_q;
  logic [7:0]  syn_q;
  logic        chan_q, ce_q, ue_q, ce_en_q, ue_en_q;

  logic st_wr, en_wr, clr_ce, clr_ue, ce_keep, ue_keep, take_ue, take_ce;
  logic unused_bits;

  assign st_wr   = reg_we && reg_idx == IDX_STAT;
  assign en_wr   = reg_we && reg_idx == IDX_EN;
  assign clr_ce  = st_wr && reg_wdata[CE_BIT];
  assign clr_ue  = st_wr && reg_wdata[UE_BIT];
  assign ce_keep = ce_q && !clr_ce;
  assign ue_keep = ue_q && !clr_ue;
  assign take_ue = ue_evt && !ue_keep;
  assign take_ce = ce_evt && !ue_evt && !ce_keep && !ue_keep;
  assign unused_bits = ^{reg_wdata[31:9], reg_wdata[6:1], err_addr[11:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q   <= '0;
      syn_q   <= '0;
      chan_q  <= 1'b0;
      ce_q    <= 1'b0;
      ue_q    <= 1'b0;
      ce_en_q <= 1'b0;
      ue_en_q <= 1'b0;
    end else begin
      ce_q <= ce_keep || ce_evt;
      ue_q <= ue_keep || ue_evt;
      if (take_ue || take_ce) begin
        blk_q  <= err_addr[31:12];
        syn_q  <= err_syn;
        chan_q <= err_chan;
      end
      if (en_wr) begin
        ce_en_q <= reg_wdata[CE_EN_BIT];
        ue_en_q <= reg_wdata[UE_EN_BIT];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_ADDR: reg_rdata[31:12] = blk_q;
      IDX_INFO: begin
        reg_rdata[7:0] = syn_q;
        reg_rdata[8]   = chan_q;
      end
      IDX_STAT: begin
        reg_rdata[CE_BIT] = ce_q;
        reg_rdata[UE_BIT] = ue_q;
      end
      default: begin
        reg_rdata[CE_EN_BIT] = ce_en_q;
        reg_rdata[UE_EN_BIT] = ue_en_q;
      end
    endcase
  end

  assign irq = (ce_q && ce_en_q) || (ue_q && ue_en_q);

  assert_ce_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt |=> ce_q);
  assert_ue_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt |=> ue_q);
  assert_ue_over_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && !ue_q) |=> (blk_q == $past(err_addr[31:12]) && syn_q == $past(err_syn)));
  assert_ce_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !ue_evt && (ce_q || ue_q) && !st_wr) |=>
      ($stable(blk_q) && $stable(syn_q) && $stable(chan_q)));
  assert_ue_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_q && !st_wr) |=> ($stable(blk_q) && $stable(syn_q) && $stable(chan_q)));
  assert_write_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !reg_wdata[CE_BIT] && ce_q) |=> ce_q);
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_en_q && !ue_en_q) |-> !irq);
endmodule

// File: tb/ecc_err_log_test.sv
module ecc_err_log_test;
  logic clk = 0, rst_n = 0;
  logic ce_evt = 0, ue_evt = 0, err_chan = 0, reg_we = 0;
  logic [31:0] err_addr = 0, reg_wdata = 0, reg_rdata;
  logic [7:0] err_syn = 0;
  logic [1:0] reg_idx = 0;
  logic irq;
  int nvec = 0, nbad = 0;

  logic [19:0] m_blk;
  logic [7:0]  m_syn;
  logic m_ch, m_ce, m_ue, m_ence, m_enue;

  ecc_err_log uut (.*);

  always #5 clk = ~clk;

  initial begin
    #2000000;
    nbad++;
    $display("FAIL watchdog: run did not finish (got hang, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    reg_idx = 2'd0; #1;
    cmp({"R2 R3 R4 R5 R6 R10 addr ", ctx}, reg_rdata, {m_blk, 12'h000});
    reg_idx = 2'd1; #1;
    cmp({"R2 R4 R5 info ", ctx}, reg_rdata, {23'd0, m_ch, m_syn});
    reg_idx = 2'd2; #1;
    cmp({"R7 status ", ctx}, reg_rdata, {24'd0, m_ue, 6'd0, m_ce});
    reg_idx = 2'd3; #1;
    cmp({"R8 enable ", ctx}, reg_rdata, {23'd0, m_enue, m_ence, 7'd0});
    cmp({"R9 irq ", ctx}, {31'd0, irq}, {31'd0, (m_ce & m_ence) | (m_ue & m_enue)});
  endtask

  task automatic step(input logic ce, input logic ue, input logic [31:0] a,
                      input logic [7:0] s, input logic c, input logic we,
                      input logic [1:0] wi, input logic [31:0] wd);
    logic ck, uk;
    @(negedge clk);
    ce_evt = ce; ue_evt = ue; err_addr = a; err_syn = s; err_chan = c;
    reg_we = we; reg_idx = wi; reg_wdata = wd;
    ck = m_ce & ~(we && wi == 2'd2 && wd[0]);
    uk = m_ue & ~(we && wi == 2'd2 && wd[7]);
    if ((ue && !uk) || (ce && !ue && !ck && !uk)) begin
      m_blk = a[31:12]; m_syn = s; m_ch = c;
    end
    m_ce = ck | ce;
    m_ue = uk | ue;
    if (we && wi == 2'd3) begin m_ence = wd[7]; m_enue = wd[8]; end
    @(negedge clk);
    ce_evt = 0; ue_evt = 0; reg_we = 0;
  endtask

  initial begin
    m_blk = 0; m_syn = 0; m_ch = 0; m_ce = 0; m_ue = 0; m_ence = 0; m_enue = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset");
    for (int en = 0; en < 4; en++)
      for (int e1 = 0; e1 < 4; e1++)
        for (int e2 = 0; e2 < 4; e2++)
          for (int cl = 0; cl < 4; cl++) begin
            automatic int k = en * 64 + e1 * 16 + e2 * 4 + cl;
            automatic logic [31:0] a1 = 32'h1234_5ABC ^ (k << 12);
            automatic logic [31:0] a2 = 32'hFEDC_B777 ^ (k << 14);
            step(0, 0, 0, 0, 0, 1, 2'd2, 32'h0000_0081);
            step(0, 0, 0, 0, 0, 1, 2'd3, 32'hFFFF_FE7F ^ ((en & 1) ? 32'h0 : 32'h80)
                                         ^ ((en & 2) ? 32'h0 : 32'h100));
            check_all("R8 enable write");
            step(e1[0], e1[1], a1, 8'(k * 37 + 5), k[0], 0, 2'd0, 0);
            check_all("R2 R3 R6 first event");
            step(e2[0], e2[1], a2, 8'(k * 11 + 200), ~k[0], 1, 2'd2,
                 {24'd0, cl[1], 6'h2A, cl[0]});
            check_all("R3 R4 R5 R7 second event with clear");
            step(0, 0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FF7E);
            check_all("R7 write zero");
            step(0, 0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF);
            step(0, 0, 0, 0, 0, 1, 2'd1, 32'hFFFF_FFFF);
            check_all("R10 read-only words");
          end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule